// File: doc/BRIEF.md
# Manual Tune Memory Loader

This block owns a small byte memory that holds a melody. It has two ways of moving through that memory. In program mode an operator works three push buttons. One button returns the address to zero. One moves it forward by one location. One stores the byte currently set on an 8-bit key value at the current address. In run mode a free-running internal divider steps through the memory on its own. At each step it hands the stored byte to a tone-generator interface as a one-cycle strobe.

During run mode a stop input freezes the stepping until a restart button is pressed. Both modes share one address counter. An indicator vector mirrors the counter bit for bit, so all indicators lit means the final location. A second indicator vector holds the last byte written, which lets the operator confirm each entry. Every button is synchronised and edge-detected, so a press of any length causes exactly one action.

Top module: `tune_loader`

## Requirements
- R1: The memory holds 2^AW locations of DW bits, and the address is AW bits wide (defaults AW=11 and DW=8, giving 2048 bytes).
- R2: A press of the clear button sets the address to zero in either mode. Every button press takes effect at the third rising clock edge at which the button is sampled high.
- R3: In program mode each step press adds one to the address, and the address wraps from all ones to zero. Otherwise the program-mode address changes only through a step or clear press.
- R4: In program mode a write press drives mem_we_n low (active low) for exactly the one cycle before its action edge. At that edge key_data is stored at the current address, and data_leds then shows that byte until the next accepted write.
- R5: In run mode write presses and step presses are ignored: mem_we_n stays high, data_leds keeps its value, and the address moves only with the divider.
- R6: addr_leds equals mem_addr bit for bit, with bit 0 being the lowest indicator, so all bits set marks the last location.
- R7: In run mode, when not halted, the address advances once every TICK_DIV cycles. At that same edge tone_valid rises for one cycle, and tone_byte carries the byte stored at the address before the advance.
- R8: If stop_req is high at a rising edge in run mode, stepping halts from the next edge: no tone strobes, the address is held and the divider is held. A restart press resumes stepping. When a stop and a restart meet at the same edge, the stop wins.
- R9: Holding a button high for any number of cycles produces only one action.
- R10: The synchronous active-high reset sets the address, divider, halt state, data_leds and tone outputs to zero and clears the button synchronisers. mem_we_n is high after reset.
- R11: Leaving run mode returns the divider to zero and keeps the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_run | input | 1 | 1 selects run mode, 0 selects program mode |
| btn_clr | input | 1 | Address clear button |
| btn_step | input | 1 | Address step button |
| btn_wr | input | 1 | Write button |
| btn_resume | input | 1 | Restart button for halted play |
| key_data | input | DW | Byte from the key matrix |
| stop_req | input | 1 | Halt request, sampled in run mode |
| mem_addr | output | AW | Current memory address |
| mem_we_n | output | 1 | Memory write enable, active low |
| addr_leds | output | AW | Address indicator vector |
| data_leds | output | DW | Last written byte |
| tone_valid | output | 1 | One-cycle strobe for a played byte |
| tone_byte | output | DW | Byte handed to the tone generator |

## Verification
The bench builds the block with AW=4 and TICK_DIV=3. Sixteen locations let the bench program every address, see all indicators lit and wrap to zero in a few dozen presses. A three-cycle divider lets run mode lap the whole memory several times, so halts, restarts and mode changes can be placed at many divider phases. Each played byte is compared against what was written, and this exercises the wrap on both the stepping path and the playback path.

// File: rtl/tl_pkg.sv
package tl_pkg;
    localparam int NUM_BTN = 4;

    typedef enum int {
        BTN_CLR    = 0,
        BTN_STEP   = 1,
        BTN_WR     = 2,
        BTN_RESUME = 3
    } btn_idx_e;

    typedef enum logic [0:0] {
        PLAY_GO   = 1'b0,
        PLAY_HALT = 1'b1
    } play_st_e;

    function automatic int ctr_width(input int limit);
        return (limit > 1) ? $clog2(limit) : 1;
    endfunction
endpackage

// File: rtl/tl_btn_cond.sv
module tl_btn_cond #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    output logic [N-1:0] pulse
);
    for (genvar i = 0; i < N; i++) begin : g_btn
        logic meta_q, sync_q, last_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                last_q <= 1'b0;
            end else begin
                meta_q <= raw[i];
                sync_q <= meta_q;
                last_q <= sync_q;
            end
        end
        assign pulse[i] = sync_q & ~last_q;
    end
endmodule

// File: rtl/tl_addr_ctr.sv
module tl_addr_ctr #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          adv,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst)      addr_q <= '0;
        else if (clr) addr_q <= '0;
        else if (adv) addr_q <= addr_q + 1'b1;
    end

    assign addr = addr_q;

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr |=> (addr == '0)); // R2
    AST_ADV_INC: assert property (@(posedge clk) disable iff (rst)
        (adv && !clr) |=> (addr == $past(addr) + 1'b1)); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!adv && !clr) |=> $stable(addr)); // R3
endmodule

// File: rtl/tl_play_gate.sv
module tl_play_gate
    import tl_pkg::*;
#(
    parameter int TICK_DIV = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic stop_req,
    input  logic resume,
    output logic tick,
    output logic halted
);
    localparam int CW = ctr_width(TICK_DIV);
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    play_st_e      st_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PLAY_GO;
            cnt_q <= '0;
        end else begin
            if (run && stop_req) st_q <= PLAY_HALT;
            else if (resume)     st_q <= PLAY_GO;

            if (!run)                  cnt_q <= '0;
            else if (st_q == PLAY_GO)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign tick   = run && (st_q == PLAY_GO) && (cnt_q == LAST);
    assign halted = (st_q == PLAY_HALT);
endmodule

// File: rtl/tl_mem.sv
module tl_mem #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (!we_n) cells[addr] <= wdata;
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/tune_loader.sv
module tune_loader
    import tl_pkg::*;
#(
    parameter int AW       = 11,
    parameter int DW       = 8,
    parameter int TICK_DIV = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_run,
    input  logic          btn_clr,
    input  logic          btn_step,
    input  logic          btn_wr,
    input  logic          btn_resume,
    input  logic [DW-1:0] key_data,
    input  logic          stop_req,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we_n,
    output logic [AW-1:0] addr_leds,
    output logic [DW-1:0] data_leds,
    output logic          tone_valid,
    output logic [DW-1:0] tone_byte
);
    logic [NUM_BTN-1:0] raw, pulse;
    logic               tick, halted, adv, wr_fire;
    logic [DW-1:0]      rdata, leds_q, tone_q;
    logic               tone_v_q;

    assign raw[BTN_CLR]    = btn_clr;
    assign raw[BTN_STEP]   = btn_step;
    assign raw[BTN_WR]     = btn_wr;
    assign raw[BTN_RESUME] = btn_resume;

    tl_btn_cond #(.N(NUM_BTN)) u_btn (
        .clk(clk), .rst(rst), .raw(raw), .pulse(pulse)
    );

    tl_play_gate #(.TICK_DIV(TICK_DIV)) u_gate (
        .clk(clk), .rst(rst), .run(mode_run), .stop_req(stop_req),
        .resume(pulse[BTN_RESUME]), .tick(tick), .halted(halted)
    );

    assign adv = mode_run ? tick : pulse[BTN_STEP];

    tl_addr_ctr #(.AW(AW)) u_ctr (
        .clk(clk), .rst(rst), .clr(pulse[BTN_CLR]), .adv(adv), .addr(mem_addr)
    );

    assign wr_fire  = pulse[BTN_WR] & ~mode_run;
    assign mem_we_n = ~wr_fire;

    tl_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk(clk), .we_n(mem_we_n), .addr(mem_addr), .wdata(key_data), .rdata(rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            leds_q   <= '0;
            tone_q   <= '0;
            tone_v_q <= 1'b0;
        end else begin
            if (wr_fire) leds_q <= key_data;
            tone_v_q <= tick;
            if (tick) tone_q <= rdata;
        end
    end

    assign addr_leds  = mem_addr;
    assign data_leds  = leds_q;
    assign tone_valid = tone_v_q;
    assign tone_byte  = tone_q;

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |=> mem_we_n); // R9
    AST_LED_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |=> (data_leds == $past(key_data))); // R4
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (mode_run && halted && !pulse[BTN_CLR]) |=> $stable(mem_addr)); // R8
    AST_TONE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (tick && !pulse[BTN_CLR]) |=> (tone_valid && mem_addr == $past(mem_addr) + 1'b1)); // R7
endmodule

// File: tb/tune_loader_tb.sv
`timescale 1ns/1ps
module tune_loader_tb_top;
    localparam int AW  = 4;
    localparam int DW  = 8;
    localparam int DIV = 3;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_run = 1'b0;
    logic btn_clr = 1'b0, btn_step = 1'b0, btn_wr = 1'b0, btn_resume = 1'b0;
    logic [DW-1:0] key_data = '0;
    logic stop_req = 1'b0;
    logic [AW-1:0] mem_addr, addr_leds;
    logic mem_we_n, tone_valid;
    logic [DW-1:0] data_leds, tone_byte;

    always #2 clk = ~clk;

    tune_loader #(.AW(AW), .DW(DW), .TICK_DIV(DIV)) dut_i (
        .clk(clk), .rst(rst), .mode_run(mode_run), .btn_clr(btn_clr),
        .btn_step(btn_step), .btn_wr(btn_wr), .btn_resume(btn_resume),
        .key_data(key_data), .stop_req(stop_req), .mem_addr(mem_addr),
        .mem_we_n(mem_we_n), .addr_leds(addr_leds), .data_leds(data_leds),
        .tone_valid(tone_valid), .tone_byte(tone_byte)
    );

    int checks = 0, failures = 0;
    bit done = 0, primed = 0;
    int run_we_low = 0;

    // Behavioural reference model. Button order: 0 clr, 1 step, 2 wr, 3 resume.
    bit [3:0] h1, h2, h3;
    int m_addr, m_cnt, m_leds, m_tone, m_tv;
    bit m_halt;
    int m_mem [int];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit [3:0] p;
        bit tick;
        int nxt;
        primed = 1;
        if (rst) begin
            h1 = 0; h2 = 0; h3 = 0;
            m_addr = 0; m_cnt = 0; m_leds = 0; m_tone = 0; m_tv = 0; m_halt = 0;
        end else begin
            p = h2 & ~h3;
            tick = mode_run && !m_halt && (m_cnt == DIV - 1);
            if (p[2] && !mode_run) begin
                m_mem[m_addr] = key_data;
                m_leds = key_data;
            end
            m_tv = tick;
            if (tick) m_tone = m_mem.exists(m_addr) ? m_mem[m_addr] : -1;
            nxt = m_addr;
            if (p[0]) nxt = 0;
            else if ((!mode_run && p[1]) || tick) nxt = (m_addr + 1) % DEPTH;
            if (!mode_run) m_cnt = 0;
            else if (!m_halt) m_cnt = (m_cnt == DIV - 1) ? 0 : m_cnt + 1;
            if (mode_run && stop_req) m_halt = 1;
            else if (p[3]) m_halt = 0;
            m_addr = nxt;
            h3 = h2; h2 = h1;
            h1 = {btn_resume, btn_wr, btn_step, btn_clr};
        end
    end

    always @(negedge clk) begin
        bit pw;
        if (primed && !done) begin
            pw = h2[2] && !h3[2] && !mode_run && !rst;
            chk(mem_addr == AW'(m_addr), "R3 address", mem_addr, m_addr);
            chk(addr_leds == mem_addr, "R6 addr_leds", addr_leds, mem_addr);
            chk(mem_we_n == !pw, "R4 mem_we_n", mem_we_n, !pw);
            chk(data_leds == DW'(m_leds), "R4 data_leds", data_leds, m_leds);
            chk(tone_valid == m_tv[0], "R7 tone_valid", tone_valid, m_tv);
            if (m_tv != 0 && m_tone >= 0)
                chk(tone_byte == DW'(m_tone), "R7 tone_byte", tone_byte, m_tone);
            if (mode_run && !mem_we_n) run_we_low++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic press_clr(input int hold);
        btn_clr = 1; cyc(hold); btn_clr = 0; cyc(4);
    endtask
    task automatic press_step(input int hold);
        btn_step = 1; cyc(hold); btn_step = 0; cyc(4);
    endtask
    task automatic press_wr(input logic [DW-1:0] v, input int hold);
        key_data = v; btn_wr = 1; cyc(hold); btn_wr = 0; cyc(4);
    endtask
    task automatic press_resume();
        btn_resume = 1; cyc(2); btn_resume = 0; cyc(1);
    endtask

    initial begin
        int held;
        cyc(3);
        rst = 0;
        #0;
        chk(mem_addr == 0 && mem_we_n && tone_valid == 0 && data_leds == 0,
            "R10 reset state", mem_addr, 0);
        // R2 clear then first location loaded with zero
        press_clr(3);
        chk(addr_leds == 0, "R2 cleared indicators", addr_leds, 0);
        press_wr(8'h00, 2);
        press_step(1);
        chk(addr_leds == 1, "R6 bit0 after first step", addr_leds, 1);
        for (int i = 1; i < DEPTH; i++) begin
            press_wr(DW'((i * 37 + 11) ^ (i << 4)), 1 + (i % 3));
            if (i < DEPTH - 1) press_step(1 + (i % 2));
        end
        chk(addr_leds == AW'(DEPTH - 1), "R6 all indicators at last location", addr_leds, DEPTH - 1);
        press_step(2);
        chk(mem_addr == 0, "R1 R3 wrap to zero", mem_addr, 0);
        // R9 long hold produces one step
        btn_step = 1; cyc(12); btn_step = 0; cyc(4);
        chk(mem_addr == 1, "R9 held step once", mem_addr, 1);
        held = data_leds;
        press_clr(1);
        // run mode with ignored buttons
        mode_run = 1;
        cyc(10);
        press_wr(8'hFF, 2);
        press_step(2);
        chk(data_leds == DW'(held), "R5 leds unchanged in run", data_leds, held);
        cyc(40);
        // halt and resume
        stop_req = 1; cyc(1); stop_req = 0;
        cyc(1);
        held = mem_addr;
        cyc(20);
        chk(mem_addr == AW'(held) && !tone_valid, "R8 halted holds address", mem_addr, held);
        btn_resume = 1; stop_req = 1; cyc(4); btn_resume = 0; stop_req = 0; cyc(6);
        chk(mem_addr == AW'(held), "R8 stop beats restart", mem_addr, held);
        press_resume();
        cyc(20);
        chk(mem_addr != AW'(held), "R8 resumed stepping", mem_addr, held);
        press_clr(2);
        cyc(30);
        // R11 leave run mode mid-divider, then return
        mode_run = 0; cyc(5);
        held = mem_addr;
        cyc(5);
        chk(mem_addr == AW'(held), "R11 address kept in program mode", mem_addr, held);
        mode_run = 1; cyc(60);
        mode_run = 0; cyc(5);
        chk(run_we_low == 0, "R5 no write strobe in run", run_we_low, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule